// File: doc/BRIEF.md
# Burst-of-Two Quad-Rate SRAM Model

A synthesizable behavioural model of a synchronous static RAM that has separate read and write ports. The two ports share one address bus, and data moves on both halves of the clock. Every access moves two words: beat 0 and beat 1. The input clock `k_i` acts as the positive clock, and its falling edge acts as the complementary input clock. Read data leaves on the rising and falling edges of the output clock `c_i`. When the `SINGLE_CLK` parameter is set, read data leaves on the edges of `k_i` instead.

The storage is two half-arrays, one for each beat, and both are indexed by the same word address. Writes are masked per 9-bit lane, with one active-low select per lane and per beat. A data-valid flag takes the place of an output enable: while it is low, the data outputs read zero. Two free-running echo clocks follow whichever clock launches the read data.

A controller issues at most one read and one write in each `k_i` cycle. It presents the read address before the rising edge of `k_i` and the write address before the falling edge.

Top module: `qdr_b2_sram`

## Requirements
- R1: The write port is selected by `wps_ni` sampled low at a `k_i` rising edge. If it is sampled high, no write takes place in that cycle: every lane of every row keeps its contents, whatever `d_i`, `bws_ni` and `addr_i` carry.
- R2: `addr_i` sampled at a `k_i` rising edge is the read address. `addr_i` sampled at the following `k_i` falling edge is the write address. The two may differ in the same cycle.
- R3: A write stores the `d_i` sampled at the `k_i` rising edge as beat 0 and the `d_i` sampled at the following falling edge as beat 1. Both beats go to the same row.
- R4: Bit l of `bws_ni` (active low) governs data bits 9l+8 down to 9l. It is sampled on the same edge as the beat it masks. A lane whose bit is high keeps its stored value.
- R5: A read issued at `k_i` rising edge n drives beat 0 from the output-clock rising edge that follows `k_i` rising edge n+RD_LAT, and beat 1 from the output-clock falling edge after that. `qvld_o` is high across both beats.
- R6: A read and a write to the same row in the same cycle return the row's previous contents. A read in the next cycle returns the new contents.
- R7: When no read was issued at edge n, `qvld_o` is low and `q_o` is all zero from the output-clock rising edge that follows edge n+RD_LAT. A read issued earlier still completes.
- R8: `cq_o` follows the output clock, `cqn_o` is its complement, and both run whatever the traffic.
- R9: With `SINGLE_CLK`=1, both beats launch on the `k_i` rising and falling edges, in the same cycle as in R5. `c_i` is ignored.
- R10: An asserted `rst_ni` asynchronously clears both half-arrays to zero, drops `qvld_o` and forces `q_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| k_i | input | 1 | Input clock; the rising edge is the primary capture edge and the falling edge is the complementary one |
| c_i | input | 1 | Output clock; the falling edge launches beat 1 |
| rps_ni | input | 1 | Read select, active low, sampled at `k_i` rise |
| wps_ni | input | 1 | Write select, active low, sampled at `k_i` rise |
| addr_i | input | ADDR_W | Shared address: read address at the rise, write address at the fall |
| d_i | input | 9*LANES | Write data, one beat on each `k_i` edge |
| bws_ni | input | LANES | Per-lane write selects, active low, sampled with each beat |
| q_o | output | 9*LANES | Read data, zero while not valid |
| qvld_o | output | 1 | Read data valid |
| cq_o | output | 1 | Echo clock |
| cqn_o | output | 1 | Complementary echo clock |

## Verification
A stimulus table mixes several kinds of traffic: full writes, reads of rows never written, writes masked differently in each beat, a write whose select is high while its data and masks are active, and reads and writes to the same row or to different rows in one cycle. Rows never written tell a cleared array apart from stale data. Opposite masks in the two beats show whether each beat takes its own lane selects. The same-row pair pins down read-before-write ordering, and the different-row pair separates the read address from the write address. Two instances, one with each output-clock choice, share the stimulus so that their launch cycles can be compared. An idle cycle between reads and a reset with a read in flight show that the valid flag drops and that the array clears.

// File: rtl/qdr_b2_pkg.sv
`timescale 1ns/1ps
package qdr_b2_pkg;
  localparam int LANE_W = 9;
  localparam int BEATS  = 2;
endpackage

// File: rtl/qdr_half_array.sv
`timescale 1ns/1ps
module qdr_half_array
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input  logic                      rst_ni,
  input  logic                      clk_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         waddr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  input  logic [LANES-1:0]          wlane_ni,
  input  logic [ADDR_W-1:0]         raddr_i,
  output logic [LANES*LANE_W-1:0]   rdata_o
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      for (int l = 0; l < LANES; l++)
        if (!wlane_ni[l]) mem_q[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/qdr_rd_pipe.sv
`timescale 1ns/1ps
module qdr_rd_pipe #(
  parameter int W      = 72,
  parameter int STAGES = 2
) (
  input  logic         rst_ni,
  input  logic         clk_i,
  input  logic         in_vld_i,
  input  logic [W-1:0] in_data_i,
  output logic         out_vld_o,
  output logic [W-1:0] out_data_o
);
  logic [STAGES-1:0]        vld_q;
  logic [STAGES-1:0][W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      data_q <= '0;
    end else begin
      vld_q[0]  <= in_vld_i;
      // idle slots carry zero so the output needs no extra gating
      data_q[0] <= in_vld_i ? in_data_i : '0;
      for (int s = 1; s < STAGES; s++) begin
        vld_q[s]  <= vld_q[s-1];
        data_q[s] <= data_q[s-1];
      end
    end
  end

  assign out_vld_o  = vld_q[STAGES-1];
  assign out_data_o = data_q[STAGES-1];
endmodule

// File: rtl/qdr_out_stage.sv
`timescale 1ns/1ps
module qdr_out_stage #(
  parameter int DW = 36
) (
  input  logic          rst_ni,
  input  logic          oclk_i,
  input  logic          vld_i,
  input  logic [DW-1:0] w0_i,
  input  logic [DW-1:0] w1_i,
  output logic [DW-1:0] q_o,
  output logic          qvld_o
);
  logic          vld_q;
  logic [DW-1:0] w0_q, w1_q;

  always_ff @(posedge oclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      w0_q  <= '0;
      w1_q  <= '0;
    end else begin
      vld_q <= vld_i;
      w0_q  <= w0_i;
      w1_q  <= w1_i;
    end
  end

  // high phase carries beat 0, low phase beat 1
  assign q_o    = oclk_i ? w0_q : w1_q;
  assign qvld_o = vld_q;
endmodule

// File: rtl/qdr_b2_sram.sv
`timescale 1ns/1ps
module qdr_b2_sram
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int LANES      = 4,
  parameter int RD_LAT     = 2,
  parameter bit SINGLE_CLK = 1'b0
) (
  input  logic                    rst_ni,
  input  logic                    k_i,
  input  logic                    c_i,
  input  logic                    rps_ni,
  input  logic                    wps_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] d_i,
  input  logic [LANES-1:0]        bws_ni,
  output logic [LANES*LANE_W-1:0] q_o,
  output logic                    qvld_o,
  output logic                    cq_o,
  output logic                    cqn_o
);
  localparam int DW     = LANES * LANE_W;
  // the separate output clock lags k_i, so it needs one more retiming stage
  localparam int PIPE_N = SINGLE_CLK ? RD_LAT : RD_LAT + 1;

  logic             kn;
  logic             oclk;
  logic             wr_pend_q;
  logic [DW-1:0]    d0_q;
  logic [LANES-1:0] bws0_q;
  logic [DW-1:0]    wbeat [BEATS];
  logic [LANES-1:0] wlane [BEATS];
  logic [DW-1:0]    rbeat [BEATS];
  logic             pipe_vld;
  logic [2*DW-1:0]  pipe_data;

  assign kn = ~k_i;

  always_ff @(posedge k_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_pend_q <= 1'b0;
      d0_q      <= '0;
      bws0_q    <= '1;
    end else begin
      wr_pend_q <= ~wps_ni;
      d0_q      <= d_i;
      bws0_q    <= bws_ni;
    end
  end

  assign wbeat[0] = d0_q;
  assign wlane[0] = bws0_q;
  assign wbeat[1] = d_i;
  assign wlane[1] = bws_ni;

  for (genvar b = 0; b < BEATS; b++) begin : g_half
    qdr_half_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_arr (
      .rst_ni  (rst_ni),
      .clk_i   (kn),
      .we_i    (wr_pend_q),
      .waddr_i (addr_i),
      .wdata_i (wbeat[b]),
      .wlane_ni(wlane[b]),
      .raddr_i (addr_i),
      .rdata_o (rbeat[b])
    );
  end

  qdr_rd_pipe #(.W(2*DW), .STAGES(PIPE_N)) u_pipe (
    .rst_ni    (rst_ni),
    .clk_i     (k_i),
    .in_vld_i  (~rps_ni),
    .in_data_i ({rbeat[1], rbeat[0]}),
    .out_vld_o (pipe_vld),
    .out_data_o(pipe_data)
  );

  if (SINGLE_CLK) begin : g_kclk
    logic c_unused;
    assign c_unused = c_i;
    assign oclk     = k_i;
  end else begin : g_cclk
    assign oclk = c_i;
  end

  qdr_out_stage #(.DW(DW)) u_out (
    .rst_ni(rst_ni),
    .oclk_i(oclk),
    .vld_i (pipe_vld),
    .w0_i  (pipe_data[DW-1:0]),
    .w1_i  (pipe_data[2*DW-1:DW]),
    .q_o   (q_o),
    .qvld_o(qvld_o)
  );

  assign cq_o  = oclk;
  assign cqn_o = ~oclk;
endmodule

// File: rtl/qdr_b2_sram_chk.sv
`timescale 1ns/1ps
module qdr_b2_sram_chk
  import qdr_b2_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int RD_LAT = 2
) (
  input logic                    rst_ni,
  input logic                    k_i,
  input logic                    rps_ni,
  input logic [LANES*LANE_W-1:0] q_o,
  input logic                    qvld_o,
  input logic                    cq_o,
  input logic                    cqn_o
);
  logic [RD_LAT:0] rd_hist_q;

  always_ff @(posedge k_i or negedge rst_ni) begin
    if (!rst_ni) rd_hist_q <= '0;
    else         rd_hist_q <= {rd_hist_q[RD_LAT-1:0], ~rps_ni};
  end

  // R5
  rd_valid_chk: assert property (@(negedge cq_o) disable iff (!rst_ni)
    qvld_o == rd_hist_q[RD_LAT]);

  // R7
  idle_zero_chk: assert property (@(negedge cq_o) disable iff (!rst_ni)
    !rd_hist_q[RD_LAT] |-> q_o == '0);

  // R8
  echo_fall_chk: assert property (@(negedge cq_o) disable iff (!rst_ni) !cqn_o);

  // R8
  echo_rise_chk: assert property (@(posedge cq_o) disable iff (!rst_ni) cqn_o);

  // R10
  no_unknown_chk: assert property (@(posedge k_i) disable iff (!rst_ni)
    !$isunknown({q_o, qvld_o}));
endmodule

bind qdr_b2_sram qdr_b2_sram_chk #(.LANES(LANES), .RD_LAT(RD_LAT)) u_chk (
  .rst_ni(rst_ni),
  .k_i   (k_i),
  .rps_ni(rps_ni),
  .q_o   (q_o),
  .qvld_o(qvld_o),
  .cq_o  (cq_o),
  .cqn_o (cqn_o)
);

// File: tb/qdr_b2_sram_tb_top.sv
`timescale 1ns/1ps
module qdr_b2_sram_tb_top;
  import qdr_b2_pkg::*;

  localparam int AW    = 4;
  localparam int LN    = 4;
  localparam int DW    = LN * LANE_W;
  localparam int LAT   = 2;
  localparam int DEPTH = 1 << AW;
  localparam int MAXC  = 512;

  typedef struct packed {
    logic          rd;
    logic [AW-1:0] ra;
    logic          wr;
    logic [AW-1:0] wa;
    logic [DW-1:0] d0;
    logic [LN-1:0] b0;
    logic [DW-1:0] d1;
    logic [LN-1:0] b1;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0,  1'b1, 4'd3,  36'h111111111, 4'h0, 36'h222222222, 4'h0}, // R3 full write
    '{1'b1, 4'd3,  1'b1, 4'd5,  36'hAAAAAAAAA, 4'h0, 36'h555555555, 4'h0}, // R2 read 3, write 5
    '{1'b1, 4'd5,  1'b1, 4'd3,  36'hFFFFFFFFF, 4'hA, 36'h000000000, 4'h5}, // R4 per-beat masks
    '{1'b1, 4'd3,  1'b0, 4'd0,  36'h0,         4'hF, 36'h0,         4'hF}, // R4 merged readback
    '{1'b0, 4'd0,  1'b0, 4'd7,  36'h3C3C3C3C3, 4'h0, 36'hC3C3C3C3C, 4'h0}, // R1 deselected write
    '{1'b1, 4'd7,  1'b0, 4'd0,  36'h0,         4'hF, 36'h0,         4'hF}, // R1 row 7 still zero
    '{1'b1, 4'd5,  1'b1, 4'd5,  36'h123456789, 4'h0, 36'h9ABCDEF01, 4'h0}, // R6 same row, old data
    '{1'b1, 4'd5,  1'b0, 4'd0,  36'h0,         4'hF, 36'h0,         4'hF}, // R6 new data
    '{1'b0, 4'd0,  1'b0, 4'd0,  36'h0,         4'hF, 36'h0,         4'hF}, // R7 idle gap
    '{1'b1, 4'd0,  1'b1, 4'd15, 36'hCAFEBABE1, 4'h0, 36'h0DEADBEEF, 4'h0}, // R10 unwritten row
    '{1'b1, 4'd15, 1'b1, 4'd15, 36'h0,         4'hF, 36'h777777777, 4'h0}, // R4 beat0 fully masked
    '{1'b1, 4'd15, 1'b0, 4'd0,  36'h0,         4'hF, 36'h0,         4'hF}, // R3 beat1 only changed
    '{1'b0, 4'd0,  1'b0, 4'd0,  36'h0,         4'hF, 36'h0,         4'hF}  // R7 pending read completes
  };

  logic          k = 1'b0, c = 1'b0, rst_n = 1'b0;
  logic          rps_n = 1'b1, wps_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d = '0;
  logic [LN-1:0] bws = '1;
  logic [DW-1:0] q_c, q_s;
  logic          v_c, v_s, cq_c, cqn_c, cq_s, cqn_s;

  logic [DW-1:0] mem0 [DEPTH];
  logic [DW-1:0] mem1 [DEPTH];
  logic          exp_v [MAXC];
  logic [DW-1:0] exp0 [MAXC];
  logic [DW-1:0] exp1 [MAXC];

  int   cyc = 0, n_tests = 0, n_fail = 0;
  logic chk_en = 1'b0;

  always #2 k = ~k;
  always @(k) begin
    #1;
    c = k;
  end

  qdr_b2_sram #(.ADDR_W(AW), .LANES(LN), .RD_LAT(LAT), .SINGLE_CLK(1'b0)) dut_i (
    .rst_ni(rst_n), .k_i(k), .c_i(c), .rps_ni(rps_n), .wps_ni(wps_n), .addr_i(addr),
    .d_i(d), .bws_ni(bws), .q_o(q_c), .qvld_o(v_c), .cq_o(cq_c), .cqn_o(cqn_c));

  qdr_b2_sram #(.ADDR_W(AW), .LANES(LN), .RD_LAT(LAT), .SINGLE_CLK(1'b1)) dut_s_i (
    .rst_ni(rst_n), .k_i(k), .c_i(c), .rps_ni(rps_n), .wps_ni(wps_n), .addr_i(addr),
    .d_i(d), .bws_ni(bws), .q_o(q_s), .qvld_o(v_s), .cq_o(cq_s), .cqn_o(cqn_s));

  task automatic chk(input string what, input logic [DW:0] act, input logic [DW:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [LN-1:0] bn);
    logic [DW-1:0] r = old;
    for (int l = 0; l < LN; l++)
      if (!bn[l]) r[l*LANE_W +: LANE_W] = nw[l*LANE_W +: LANE_W];
    return r;
  endfunction

  // called in the low phase of k; the next rising edge is command index cyc+1
  task automatic issue(input vec_t v);
    int idx = cyc + 1;
    rps_n = !v.rd; wps_n = !v.wr; addr = v.ra; d = v.d0; bws = v.b0;
    exp_v[idx] = v.rd;
    exp0[idx]  = v.rd ? mem0[v.ra] : '0;
    exp1[idx]  = v.rd ? mem1[v.ra] : '0;
    if (v.wr) begin
      mem0[v.wa] = merge(mem0[v.wa], v.d0, v.b0);
      mem1[v.wa] = merge(mem1[v.wa], v.d1, v.b1);
    end
    @(posedge k); #1;
    addr = v.wa; d = v.d1; bws = v.b1;
    @(negedge k); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue('{1'b0, '0, 1'b0, '0, '0, '1, '0, '1});
  endtask

  task automatic clear_model();
    for (int i = 0; i < DEPTH; i++) begin mem0[i] = '0; mem1[i] = '0; end
    for (int i = 0; i < MAXC; i++) begin exp_v[i] = 1'b0; exp0[i] = '0; exp1[i] = '0; end
  endtask

  // output monitor: both instances launch the burst of command m in cycle m+LAT
  always @(posedge k) begin
    int   m;
    logic ev;
    cyc++;
    m  = cyc - LAT;
    ev = (m >= 1 && m < MAXC) ? exp_v[m] : 1'b0;
    #1.5;
    if (chk_en) begin
      chk("R5 R7 beat0 C-clock", {v_c, q_c}, ev ? {1'b1, exp0[m]} : '0);
      chk("R9 beat0 single-clock", {v_s, q_s}, ev ? {1'b1, exp0[m]} : '0);
      chk("R8 echo high phase", {33'b0, cq_c, cqn_c, cq_s, cqn_s}, {33'b0, 4'b1010});
    end
    #2;
    if (chk_en) begin
      chk("R5 R7 beat1 C-clock", {v_c, q_c}, ev ? {1'b1, exp1[m]} : '0);
      chk("R9 beat1 single-clock", {v_s, q_s}, ev ? {1'b1, exp1[m]} : '0);
      chk("R8 echo low phase", {33'b0, cq_c, cqn_c, cq_s, cqn_s}, {33'b0, 4'b0101});
    end
  end

  initial begin
    #(4 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge k);
    #1;
    // R10 outputs quiet during reset
    chk("R10 reset C-clock", {v_c, q_c}, '0);
    chk("R10 reset single-clock", {v_s, q_s}, '0);
    rst_n  = 1'b1;
    chk_en = 1'b1;

    for (int i = 0; i < NV; i++) issue(VECS[i]);
    idle(LAT + 2);

    // R10: reset with a read in flight, then read back a previously written row
    issue('{1'b1, 4'd5, 1'b0, 4'd0, '0, '1, '0, '1});
    chk_en = 1'b0;
    rst_n  = 1'b0;
    #0.5;
    chk("R10 async clear C-clock", {v_c, q_c}, '0);
    chk("R10 async clear single-clock", {v_s, q_s}, '0);
    clear_model();
    @(negedge k); #1;
    rst_n  = 1'b1;
    chk_en = 1'b1;
    issue('{1'b1, 4'd5, 1'b0, 4'd0, '0, '1, '0, '1});
    issue('{1'b1, 4'd3, 1'b1, 4'd2, 36'h0F0F0F0F0, 4'h0, 36'h1E1E1E1E1, 4'h0});
    issue('{1'b1, 4'd2, 1'b0, 4'd0, '0, '1, '0, '1});
    idle(LAT + 2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule